// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one input clock. Each channel slows the clock by its own programmable divider, then steps a count through a programmed period. It holds its output at the active level while the count is below a programmed duty value. The polarity bit of a channel picks whether the active level is high or low.

Software programs the block through a small single-cycle register bus: a byte address, write data, a write strobe and combinational read data. One shared control word holds the per-channel enable, polarity and drive-type bits. Each channel has its own period word and duty word. One shared word packs the four divider fields, with channel 0 in the most significant field.

Period, duty and divider changes made while a channel runs are held back until the current period ends, so a running waveform is never cut short. Clearing a channel's enable resets that channel's divider and count. While a channel is disabled, its new settings apply at once.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset, every register reads zero and every output sits at logic 1, the inactive level for polarity bit 0.
- R2: The control word at byte address 0x00 holds the enable of channel n in bit n, its polarity in bit 8+n and its drive-type bit in bit 15+n. The drive-type bit is only stored. All other control bits read zero.
- R3: Channel n's period word is at 0x04+8n and its duty word at 0x08+8n, each holding a 16-bit count in bits 15:0 with bits 31:16 reading zero. Addresses outside the map read zero, and writes to them change nothing.
- R4: The divider word at 0x24 holds a 6-bit field for channel n in bits (3-n)*6+5 down to (3-n)*6, so channel 0 uses bits 23:18 and channel 3 uses bits 5:0. Bits 31:24 read zero.
- R5: An enabled channel with divider value p, period count P ≥ 2 and duty count D < P repeats every (p+1)*P clocks. It is active for the first (p+1)*D clocks of each period, starting in the cycle after the write that sets its enable.
- R6: A polarity bit of 1 gives an active-high output. A polarity bit of 0 gives an inverted output that is low while active and high otherwise.
- R7: A disabled channel drives the inactive level of its polarity (the complement of the polarity bit) from the cycle after the enable is cleared. When it is enabled again, it restarts from count zero and divider phase zero.
- R8: A duty count of 0 keeps the output inactive. A duty count at or above the period count keeps it active.
- R9: Period, duty and divider writes to a running channel take effect only at the end of its current period. Writes to a disabled channel apply from its first cycle after enabling.
- R10: Drive-type bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one clock per write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | Modulated outputs, bit n is channel n |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a running period. It must stay invisible until the period wraps, and no other write may be pending. The bench enables a slowly divided channel, waits a few clocks, and rewrites its duty in the middle of the period. It then counts active clocks across the rest of that period and across the next one. A reference model updated on every clock compares all four outputs each cycle while the channels are started, inverted, stopped and restarted in an interleaved way.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

   localparam int unsigned BUS_W      = 32;
   localparam int unsigned SLOT_COUNT = 4;    // divider fields in the shared word
   localparam int unsigned CTRL_OFS   = 'h00;
   localparam int unsigned DIV_OFS    = 'h24;
   localparam int unsigned PER_BASE   = 'h04;
   localparam int unsigned DUTY_BASE  = 'h08;
   localparam int unsigned CH_STRIDE  = 8;
   localparam int unsigned POL_LSB    = 8;
   localparam int unsigned DRV_LSB    = 15;

   function automatic int unsigned per_ofs(input int unsigned ch);
      return PER_BASE + CH_STRIDE * ch;
   endfunction

   function automatic int unsigned duty_ofs(input int unsigned ch);
      return DUTY_BASE + CH_STRIDE * ch;
   endfunction

   // channel 0 owns the most significant slot
   function automatic int unsigned div_lsb(input int unsigned ch, input int unsigned w);
      return (SLOT_COUNT - 1 - ch) * w;
   endfunction

endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
   import quad_pwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 6,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [BUS_W-1:0]                wdata,
   input  logic                            we,
   output logic [BUS_W-1:0]                rdata,
   output logic [NUM_CH-1:0]               en_q,
   output logic [NUM_CH-1:0]               pol_q,
   output logic [NUM_CH-1:0][CNT_W-1:0]    per_q,
   output logic [NUM_CH-1:0][CNT_W-1:0]    duty_q,
   output logic [NUM_CH-1:0][DIV_W-1:0]    div_q
);

   localparam int unsigned DIV_WORD_W = SLOT_COUNT * DIV_W;

   logic [NUM_CH-1:0]     drv_q;
   logic [DIV_WORD_W-1:0] div_word_q;
   logic                  hit_ctrl;
   logic                  hit_div;

   assign hit_ctrl = (int'(addr) == int'(CTRL_OFS));
   assign hit_div  = (int'(addr) == int'(DIV_OFS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= '0;
         pol_q      <= '0;
         drv_q      <= '0;
         div_word_q <= '0;
      end else if (we) begin
         if (hit_ctrl) begin
            for (int n = 0; n < int'(NUM_CH); n++) begin
               en_q[n]  <= wdata[n];
               pol_q[n] <= wdata[POL_LSB + n];
               drv_q[n] <= wdata[DRV_LSB + n];
            end
         end
         if (hit_div) begin
            div_word_q <= wdata[DIV_WORD_W-1:0];
         end
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch_regs
      logic hit_per;
      logic hit_duty;
      assign hit_per  = (int'(addr) == int'(per_ofs(n)));
      assign hit_duty = (int'(addr) == int'(duty_ofs(n)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            per_q[n]  <= '0;
            duty_q[n] <= '0;
         end else if (we) begin
            if (hit_per)  per_q[n]  <= wdata[CNT_W-1:0];
            if (hit_duty) duty_q[n] <= wdata[CNT_W-1:0];
         end
      end

      assign div_q[n] = div_word_q[div_lsb(n, DIV_W) +: DIV_W];
   end

   always_comb begin
      rdata = '0;
      if (hit_ctrl) begin
         for (int n = 0; n < int'(NUM_CH); n++) begin
            rdata[n]           = en_q[n];
            rdata[POL_LSB + n] = pol_q[n];
            rdata[DRV_LSB + n] = drv_q[n];
         end
      end
      if (hit_div) begin
         rdata[DIV_WORD_W-1:0] = div_word_q;
      end
      for (int n = 0; n < int'(NUM_CH); n++) begin
         if (int'(addr) == int'(per_ofs(n)))  rdata[CNT_W-1:0] = per_q[n];
         if (int'(addr) == int'(duty_ofs(n))) rdata[CNT_W-1:0] = duty_q[n];
      end
   end

endmodule

// File: rtl/quad_pwm_tick.sv
module quad_pwm_tick #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);

   logic [DIV_W-1:0] phase_q;
   logic             at_limit;

   assign at_limit = (phase_q == limit);
   assign tick     = !clr && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         phase_q <= '0;
      end else if (at_limit) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/quad_pwm_channel.sv
module quad_pwm_channel #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pol,
   input  logic [CNT_W-1:0] per_live,
   input  logic [CNT_W-1:0] duty_live,
   input  logic [DIV_W-1:0] div_live,
   output logic             pwm
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_s;
   logic [CNT_W-1:0] duty_s;
   logic [DIV_W-1:0] div_s;
   logic             step;
   logic             wrap;
   logic             active;

   quad_pwm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .limit (div_s),
      .tick  (step)
   );

   assign wrap = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_s};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_s  <= '0;
         duty_s <= '0;
         div_s  <= '0;
      end else if (!en) begin
         cnt_q  <= '0;
         per_s  <= per_live;
         duty_s <= duty_live;
         div_s  <= div_live;
      end else if (step) begin
         if (wrap) begin
            cnt_q  <= '0;
            per_s  <= per_live;
            duty_s <= duty_live;
            div_s  <= div_live;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign active = en && (cnt_q < duty_s);
   assign pwm    = pol ? active : !active;

endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl
   import quad_pwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 6,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_we,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   if (NUM_CH < 1 || NUM_CH > SLOT_COUNT) begin : g_bad_ch
      $error("quad_pwm_ctrl: NUM_CH must be 1 to 4");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("quad_pwm_ctrl: CNT_W out of range");
   end
   if (DIV_W < 1 || SLOT_COUNT * DIV_W > BUS_W) begin : g_bad_div
      $error("quad_pwm_ctrl: DIV_W out of range");
   end
   if ((1 << ADDR_W) <= DIV_OFS) begin : g_bad_addr
      $error("quad_pwm_ctrl: ADDR_W too narrow for the map");
   end

   logic [NUM_CH-1:0]             ctrl_en;
   logic [NUM_CH-1:0]             ctrl_pol;
   logic [NUM_CH-1:0][CNT_W-1:0]  per_w;
   logic [NUM_CH-1:0][CNT_W-1:0]  duty_w;
   logic [NUM_CH-1:0][DIV_W-1:0]  div_w;

   quad_pwm_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .we     (reg_we),
      .rdata  (reg_rdata),
      .en_q   (ctrl_en),
      .pol_q  (ctrl_pol),
      .per_q  (per_w),
      .duty_q (duty_w),
      .div_q  (div_w)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      quad_pwm_channel #(
         .CNT_W (CNT_W),
         .DIV_W (DIV_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (ctrl_en[n]),
         .pol       (ctrl_pol[n]),
         .per_live  (per_w[n]),
         .duty_live (duty_w[n]),
         .div_live  (div_w[n]),
         .pwm       (pwm_out[n])
      );
   end

endmodule

// File: rtl/quad_pwm_ctrl_chk.sv
module quad_pwm_ctrl_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] en_q,
   input logic [NUM_CH-1:0] pol_q
);

   // R2
   ctrl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |->
         (reg_rdata[31:19] == '0 && reg_rdata[14:12] == '0 && reg_rdata[7:4] == '0));

   // R3
   per_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(4)) |-> (reg_rdata[31:16] == '0));

   // R3
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(40)) |-> (reg_rdata == '0));

   // R4
   div_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(36)) |-> (reg_rdata[31:24] == '0));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      // R7
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[n] |-> (pwm_out[n] == !pol_q[n]));
   end

endmodule

bind quad_pwm_ctrl quad_pwm_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .pwm_out   (pwm_out),
   .en_q      (ctrl_en),
   .pol_q     (ctrl_pol)
);

// File: tb/quad_pwm_ctrl_test.sv
module quad_pwm_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [3:0]  pwm_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   quad_pwm_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .pwm_out   (pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int m_en [NCH];
   int m_pol[NCH];
   int m_per[NCH];
   int m_dut[NCH];
   int m_div[NCH];
   int run_phase[NCH];
   int run_step [NCH];
   int cur_per  [NCH];
   int cur_dut  [NCH];
   int cur_div  [NCH];

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_en[c] = 0; m_pol[c] = 0; m_per[c] = 0; m_dut[c] = 0; m_div[c] = 0;
         run_phase[c] = 0; run_step[c] = 0; cur_per[c] = 0; cur_dut[c] = 0; cur_div[c] = 0;
      end
   end

   function automatic logic [3:0] model_out();
      logic [3:0] v;
      for (int c = 0; c < NCH; c++) begin
         bit act;
         act  = (m_en[c] != 0) && (run_step[c] < cur_dut[c]);
         v[c] = (m_pol[c] != 0) ? act : !act;
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_pol[c] = 0; m_per[c] = 0; m_dut[c] = 0; m_div[c] = 0;
            run_phase[c] = 0; run_step[c] = 0; cur_per[c] = 0; cur_dut[c] = 0; cur_div[c] = 0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (m_en[c] == 0) begin
               run_phase[c] = 0; run_step[c] = 0;
               cur_per[c] = m_per[c]; cur_dut[c] = m_dut[c]; cur_div[c] = m_div[c];
            end else if (run_phase[c] < cur_div[c]) begin
               run_phase[c]++;
            end else begin
               run_phase[c] = 0;
               if (run_step[c] + 1 >= cur_per[c]) begin
                  run_step[c] = 0;
                  cur_per[c] = m_per[c]; cur_dut[c] = m_dut[c]; cur_div[c] = m_div[c];
               end else begin
                  run_step[c]++;
               end
            end
         end
         if (reg_we) begin
            if (reg_addr == 6'h00) begin
               for (int c = 0; c < NCH; c++) begin
                  m_en[c]  = reg_wdata[c];
                  m_pol[c] = reg_wdata[8 + c];
               end
            end
            if (reg_addr == 6'h24) begin
               for (int c = 0; c < NCH; c++) m_div[c] = (reg_wdata >> ((3 - c) * 6)) & 32'h3f;
            end
            for (int c = 0; c < NCH; c++) begin
               if (int'(reg_addr) == 4 + 8 * c) m_per[c] = reg_wdata & 32'hffff;
               if (int'(reg_addr) == 8 + 8 * c) m_dut[c] = reg_wdata & 32'hffff;
            end
         end
      end
   end

   // R5/R6/R8/R9/R10: every output compared with the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] e;
         e = model_out();
         n_tests++;
         if (pwm_out !== e) begin
            n_fail++;
            $display("FAIL R5/R9 per-cycle outputs at %0t: actual %b expected %b", $time, pwm_out, e);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic count_high(input int ch, input int cycles, output int hi);
      hi = 0;
      for (int i = 0; i < cycles; i++) begin
         if (pwm_out[ch] === 1'b1) hi++;
         @(negedge clk);
      end
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pwm_out === 4'b1111, "R1 outputs after reset", pwm_out, 4'b1111);
      rd_check(6'h00, 32'h0, "R1 control after reset");
      rd_check(6'h24, 32'h0, "R1 divider after reset");
      for (int c = 0; c < NCH; c++) begin
         rd_check(6'(4 + 8 * c), 32'h0, "R1 period after reset");
         rd_check(6'(8 + 8 * c), 32'h0, "R1 duty after reset");
      end

      // R2: control layout and spare bits
      wr(6'h00, 32'hffff_ffff);
      rd_check(6'h00, 32'h0007_8f0f, "R2 control readback mask");
      wr(6'h00, 32'h0000_8000);
      rd_check(6'h00, 32'h0000_8000, "R2 drive bit 15 alone");

      // R3: period/duty words and unmapped space
      wr(6'h04, 32'habcd_1234);
      rd_check(6'h04, 32'h0000_1234, "R3 period0 low half");
      wr(6'h20, 32'hffff_5a5a);
      rd_check(6'h20, 32'h0000_5a5a, "R3 duty3 low half");
      rd_check(6'h1c, 32'h0, "R3 period3 untouched");
      wr(6'h28, 32'hffff_ffff);
      rd_check(6'h28, 32'h0, "R3 unmapped reads zero");
      rd_check(6'h00, 32'h0000_8000, "R3 unmapped write ignored");

      // R4: divider field order
      wr(6'h24, 32'hffff_ffff);
      rd_check(6'h24, 32'h00ff_ffff, "R4 divider mask");
      wr(6'h24, (32'd2 << 18) | 32'd5);
      rd_check(6'h24, 32'h0008_0005, "R4 channel0 in top field");

      // R5/R10: ch0 div 2, period 5, duty 2 -> 15 clocks, 6 active
      wr(6'h04, 32'd5);
      wr(6'h08, 32'd2);
      wr(6'h00, 32'h0000_8101);
      count_high(0, 30, hi);
      check(hi == 12, "R5 ch0 active clocks over two periods", hi, 12);

      // R6: ch1 inverted, period 4 duty 1, divider 0
      wr(6'h0c, 32'd4);
      wr(6'h10, 32'd1);
      wr(6'h00, 32'h0000_8103);
      count_high(1, 8, hi);
      check(hi == 6, "R6 ch1 inverted high clocks", hi, 6);

      // R8: ch2 duty 0 then duty above period
      wr(6'h14, 32'd3);
      wr(6'h18, 32'd0);
      wr(6'h00, 32'h0000_8507);
      count_high(2, 12, hi);
      check(hi == 0, "R8 duty zero stays inactive", hi, 0);
      wr(6'h00, 32'h0000_8503);
      wr(6'h18, 32'd7);
      wr(6'h00, 32'h0000_8507);
      count_high(2, 12, hi);
      check(hi == 12, "R8 duty above period stays active", hi, 12);

      // R7: stop ch0, inactive level, restart from zero
      wr(6'h00, 32'h0000_8506);
      check(pwm_out[0] === 1'b0, "R7 ch0 inactive after clear", pwm_out[0], 0);
      repeat (4) @(negedge clk);
      check(pwm_out[0] === 1'b0, "R7 ch0 held while disabled", pwm_out[0], 0);
      wr(6'h00, 32'h0000_8507);
      count_high(0, 30, hi);
      check(hi == 12, "R7 ch0 restart from count zero", hi, 12);

      // R9: ch3 div 5, period 4, duty 2 -> 24 clocks, 12 active; rewrite duty mid-period
      wr(6'h1c, 32'd4);
      wr(6'h20, 32'd2);
      wr(6'h00, 32'h0000_8f0f);
      count_high(3, 3, hi);
      check(hi == 3, "R9 ch3 first clocks active", hi, 3);
      wr(6'h20, 32'd4);
      count_high(3, 20, hi);
      check(hi == 8, "R9 mid-period duty write deferred", hi, 8);
      count_high(3, 24, hi);
      check(hi == 24, "R9 new duty applies next period", hi, 24);

      // R10: drive bits toggled, outputs follow model (per-cycle compare)
      wr(6'h00, 32'h0000_0f0f);
      count_high(3, 24, hi);
      check(hi == 24, "R10 drive bits no effect on ch3", hi, 24);

      repeat (50) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule